// File: doc/BRIEF.md
# ADC Result Register With Read Lock

This block keeps the most recent 10-bit result of an analog-to-digital converter and shows it to a processor bus as two 8-bit views, a low byte and a high byte. The conversion engine delivers each result with a one-cycle valid pulse. A bus-side control bit chooses between right alignment and left alignment. In right alignment the two top result bits sit at the bottom of the high byte. In left alignment the upper eight result bits fill the high byte.

Software that needs all ten bits reads the low byte first and the high byte second. The block guarantees that both bytes come from the same conversion. A low-byte read freezes the stored result. Any result that arrives while it is frozen is thrown away. The following high-byte read releases the freeze.

A conversion-complete flag is raised for every result, including discarded ones. Software clears the flag by writing a one to it. A reader that needs only eight bits can select left alignment and read only the high byte, and this never freezes the register.

Top module: `adc_result_regs`

## Requirements
- R1: With `left_adj`=0, `data_lo` equals result bits 7..0, `data_hi` bits 1..0 equal result bits 9..8, and `data_hi` bits 7..2 are zero.
- R2: With `left_adj`=1, `data_hi` equals result bits 9..2, `data_lo` bits 7..6 equal result bits 1..0, and `data_lo` bits 5..0 are zero.
- R3: A `conv_done` pulse while the register is not frozen stores `conv_value`, and the stored value is visible on the byte outputs from the following cycle.
- R4: A `rd_lo` strobe without `rd_hi` freezes the stored result. Any conversion that arrives in the same cycle as that strobe, or in a later cycle before a `rd_hi` strobe, is discarded, and neither byte changes.
- R5: A `rd_hi` strobe releases the freeze. A conversion in the same cycle as that strobe, or in any later cycle before the next `rd_lo`, is stored.
- R6: With `left_adj`=1, a sequence of high-byte reads only (no `rd_lo`) never stops later conversions from being stored.
- R7: `irq_flag` is 1 in the cycle after every `conv_done` pulse, whether the result was stored or discarded.
- R8: A `flag_wr` with `flag_wdata`=1 clears `irq_flag` on the next cycle. A `flag_wr` with `flag_wdata`=0 leaves the flag unchanged. A `conv_done` in the same cycle as a clearing write leaves the flag set.
- R9: Changing `left_adj` changes only the byte mapping. Restoring it shows the original bytes again, and the stored 10-bit value is never altered.
- R10: Synchronous reset drives `data_lo`, `data_hi` and `irq_flag` to 0 and removes any freeze, so the first conversion after reset is stored.
- R11: `rd_lo` and `rd_hi` asserted in the same cycle count as a complete paired read and leave the register unfrozen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle pulse: a conversion finished |
| conv_value | input | 10 | Result of the finished conversion |
| left_adj | input | 1 | 1 = left-aligned byte views, 0 = right-aligned |
| rd_lo | input | 1 | Bus read strobe for the low byte |
| rd_hi | input | 1 | Bus read strobe for the high byte |
| flag_wr | input | 1 | Bus write strobe for the flag |
| flag_wdata | input | 1 | Write data; a one clears the flag |
| data_lo | output | 8 | Low byte view of the stored result |
| data_hi | output | 8 | High byte view of the stored result |
| irq_flag | output | 1 | Conversion-complete flag |

## Verification
The byte mapping is swept over every one of the 1024 result codes, once in each alignment. Expected bytes are computed by shifting in the bench. This exposes any misplaced bit and any nonzero padding. Short directed read sequences cover the freeze logic:
- low read, then a conversion;
- a conversion in the same cycle as the low read;
- a conversion in the same cycle as the high read;
- high-only reads;
- both strobes together.

These sequences distinguish a lock that engages or releases one cycle late from a correct one. Flag sequences separate a write of zero from a write of one, and a clear that collides with a new conversion.

// File: rtl/adcres_pkg.sv
package adcres_pkg;

    localparam int RES_W  = 10;
    localparam int BYTE_W = 8;
    localparam int PAIR_W = 2 * BYTE_W;
    localparam int PAD_W  = PAIR_W - RES_W;

    typedef enum logic {
        ALIGN_RIGHT = 1'b0,
        ALIGN_LEFT  = 1'b1
    } align_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } byte_pair_t;

    // Place the result at the top or the bottom of a two-byte word.
    function automatic byte_pair_t map_bytes(input logic [RES_W-1:0] res,
                                             input align_e          align);
        logic [PAIR_W-1:0] word;
        if (align == ALIGN_LEFT)
            word = {res, {PAD_W{1'b0}}};
        else
            word = {{PAD_W{1'b0}}, res};
        return byte_pair_t'(word);
    endfunction

endpackage

// File: rtl/adcres_lock_ctrl.sv
module adcres_lock_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic rd_lo,
    input  logic rd_hi,
    input  logic conv_done,
    output logic locked,
    output logic accept
);
    logic lock_q;
    logic lock_d;

    // A high read always ends a paired read; a low read alone opens one.
    always_comb begin
        if (rd_hi)
            lock_d = 1'b0;
        else
            lock_d = lock_q | rd_lo;
    end

    // A result may land only if the register is unfrozen after this cycle.
    assign accept = conv_done & ~lock_d;
    assign locked = lock_q;

    always_ff @(posedge clk) begin
        if (rst)
            lock_q <= 1'b0;
        else
            lock_q <= lock_d;
    end

    // R4
    lock_engage_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_lo && !rd_hi) |=> locked);

    // R5
    lock_release_chk: assert property (@(posedge clk) disable iff (rst)
        rd_hi |=> !locked);

    // R6
    hi_only_no_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (!locked && !rd_lo) |=> !locked);

endmodule

// File: rtl/adcres_store.sv
module adcres_store #(
    parameter int RES_W = adcres_pkg::RES_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [RES_W-1:0] din,
    output logic [RES_W-1:0] dout
);
    logic [RES_W-1:0] res_q;

    always_ff @(posedge clk) begin
        if (rst)
            res_q <= '0;
        else if (load)
            res_q <= din;
    end

    assign dout = res_q;

    // R3
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (dout == $past(din)));

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(dout));

endmodule

// File: rtl/adcres_irq_flag.sv
module adcres_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr_wr,
    input  logic clr_data,
    output logic flag
);
    logic flag_q;

    // A new completion outranks a clearing write in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (set_ev)
            flag_q <= 1'b1;
        else if (clr_wr && clr_data)
            flag_q <= 1'b0;
    end

    assign flag = flag_q;

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_ev |=> flag);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && clr_data && !set_ev) |=> !flag);

    // R8
    flag_zero_write_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !(clr_wr && clr_data)) |=> flag);

endmodule

// File: rtl/adcres_view.sv
module adcres_view #(
    parameter int RES_W  = adcres_pkg::RES_W,
    parameter int BYTE_W = adcres_pkg::BYTE_W
) (
    input  logic [RES_W-1:0]  res,
    input  logic              left_adj,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi
);
    import adcres_pkg::*;

    byte_pair_t pair;

    always_comb begin
        pair = map_bytes(res, align_e'(left_adj));
        lo   = pair.lo;
        hi   = pair.hi;
    end

endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
    parameter int RES_W  = adcres_pkg::RES_W,
    parameter int BYTE_W = adcres_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_value,
    input  logic              left_adj,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic              flag_wr,
    input  logic              flag_wdata,
    output logic [BYTE_W-1:0] data_lo,
    output logic [BYTE_W-1:0] data_hi,
    output logic              irq_flag
);
    logic             locked;
    logic             accept;
    logic [RES_W-1:0] stored;

    adcres_lock_ctrl u_lock (
        .clk       (clk),
        .rst       (rst),
        .rd_lo     (rd_lo),
        .rd_hi     (rd_hi),
        .conv_done (conv_done),
        .locked    (locked),
        .accept    (accept)
    );

    adcres_store #(.RES_W(RES_W)) u_store (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .din  (conv_value),
        .dout (stored)
    );

    adcres_view #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_view (
        .res      (stored),
        .left_adj (left_adj),
        .lo       (data_lo),
        .hi       (data_hi)
    );

    adcres_irq_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .set_ev   (conv_done),
        .clr_wr   (flag_wr),
        .clr_data (flag_wdata),
        .flag     (irq_flag)
    );

    // R4
    frozen_bytes_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && !rd_hi && !rd_lo) |=> $stable(stored));

    // R9
    align_no_store_chk: assert property (@(posedge clk) disable iff (rst)
        !conv_done |=> $stable(stored));

endmodule

// File: tb/adc_result_regs_tb.sv
module adc_result_regs_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       conv_done = 1'b0;
    logic [9:0] conv_value = '0;
    logic       left_adj = 1'b0;
    logic       rd_lo = 1'b0;
    logic       rd_hi = 1'b0;
    logic       flag_wr = 1'b0;
    logic       flag_wdata = 1'b0;
    logic [7:0] data_lo;
    logic [7:0] data_hi;
    logic       irq_flag;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    adc_result_regs u_dut (
        .clk        (clk),
        .rst        (rst),
        .conv_done  (conv_done),
        .conv_value (conv_value),
        .left_adj   (left_adj),
        .rd_lo      (rd_lo),
        .rd_hi      (rd_hi),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .data_lo    (data_lo),
        .data_hi    (data_hi),
        .irq_flag   (irq_flag)
    );

    function automatic logic [7:0] exp_lo(input logic [9:0] v, input logic la);
        return la ? 8'((v % 4) * 64) : 8'(v % 256);
    endfunction

    function automatic logic [7:0] exp_hi(input logic [9:0] v, input logic la);
        return la ? 8'(v / 4) : 8'(v / 256);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_bytes(input string tag, input logic [9:0] v, input logic la);
        chk({tag, " lo"}, 16'(data_lo), 16'(exp_lo(v, la)));
        chk({tag, " hi"}, 16'(data_hi), 16'(exp_hi(v, la)));
    endtask

    task automatic drive(input logic lo, input logic hi, input logic cd,
                         input logic [9:0] v, input logic fw, input logic fd);
        rd_lo = lo; rd_hi = hi; conv_done = cd; conv_value = v;
        flag_wr = fw; flag_wdata = fd;
        @(negedge clk);
        rd_lo = 0; rd_hi = 0; conv_done = 0; flag_wr = 0; flag_wdata = 0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 reset lo", 16'(data_lo), 16'h0);
        chk("R10 reset hi", 16'(data_hi), 16'h0);
        chk("R10 reset flag", 16'(irq_flag), 16'h0);
        rst = 0;
        @(negedge clk);

        // R1 and R3: full sweep, right aligned
        left_adj = 0;
        for (int v = 0; v < 1024; v++) begin
            drive(0, 0, 1, 10'(v), 0, 0);
            chk_bytes("R1/R3 right", 10'(v), 1'b0);
        end
        // R2: full sweep, left aligned
        left_adj = 1;
        for (int v = 0; v < 1024; v++) begin
            drive(0, 0, 1, 10'(v), 0, 0);
            chk_bytes("R2 left", 10'(v), 1'b1);
        end

        // R9: switching alignment keeps the stored value
        drive(0, 0, 1, 10'h2B5, 0, 0);
        left_adj = 0; @(negedge clk);
        chk_bytes("R9 to right", 10'h2B5, 1'b0);
        left_adj = 1; @(negedge clk);
        chk_bytes("R9 back left", 10'h2B5, 1'b1);
        left_adj = 0;

        // R4: freeze after a low read; conversions are discarded, flag still rises
        drive(0, 0, 1, 10'h155, 1, 1);
        drive(1, 0, 0, 10'h0, 1, 1);
        chk("R8 clear", 16'(irq_flag), 16'h0);
        drive(0, 0, 1, 10'h3AA, 0, 0);
        chk_bytes("R4 discard", 10'h155, 1'b0);
        chk("R7 flag on discard", 16'(irq_flag), 16'h1);
        // R4: conversion in the same cycle as the low read is discarded
        drive(0, 1, 0, 10'h0, 0, 0);
        drive(1, 0, 1, 10'h0F0, 0, 0);
        chk_bytes("R4 same-cycle lo", 10'h155, 1'b0);

        // R5: a conversion in the same cycle as the high read is stored
        drive(0, 1, 1, 10'h0F0, 0, 0);
        chk_bytes("R5 same-cycle hi", 10'h0F0, 1'b0);
        drive(1, 0, 0, 10'h0, 0, 0);
        drive(0, 1, 0, 10'h0, 0, 0);
        drive(0, 0, 1, 10'h321, 0, 0);
        chk_bytes("R5 after hi", 10'h321, 1'b0);

        // R6: high-only reads in left alignment never freeze
        left_adj = 1;
        drive(0, 1, 0, 10'h0, 0, 0);
        drive(0, 1, 0, 10'h0, 0, 0);
        drive(0, 0, 1, 10'h1C7, 0, 0);
        chk_bytes("R6 hi only", 10'h1C7, 1'b1);
        left_adj = 0;

        // R11: both strobes together leave the register unfrozen
        drive(1, 1, 0, 10'h0, 0, 0);
        drive(0, 0, 1, 10'h09C, 0, 0);
        chk_bytes("R11 paired", 10'h09C, 1'b0);

        // R8: write of zero keeps the flag; write of one clears; set wins a collision
        drive(0, 0, 0, 10'h0, 1, 0);
        chk("R8 zero write", 16'(irq_flag), 16'h1);
        drive(0, 0, 0, 10'h0, 1, 1);
        chk("R8 one write", 16'(irq_flag), 16'h0);
        drive(0, 0, 1, 10'h200, 1, 1);
        chk("R8 collision", 16'(irq_flag), 16'h1);

        // R10: reset while frozen clears state and the freeze
        drive(1, 0, 0, 10'h0, 0, 0);
        rst = 1; @(negedge clk);
        chk("R10 mid lo", 16'(data_lo), 16'h0);
        chk("R10 mid flag", 16'(irq_flag), 16'h0);
        rst = 0;
        drive(0, 0, 1, 10'h2E1, 0, 0);
        chk_bytes("R10 unfrozen", 10'h2E1, 1'b0);

        summary();
        $finish;
    end

endmodule